// File: doc/BRIEF.md
# Destination MAC address filter

This block watches a received frame stream and decides, for every frame, whether the frame may continue towards the buffer or should be dropped on the basis of its destination address. It assembles the first six octets of each frame into a 48-bit address. At end of frame it tests that address against a small software-programmed table of station addresses and a two-bit check mode. The verdict is one pass/fail pulse for each frame, issued together with that frame.

Software programs the table through a simple write port. Each entry takes two word locations, and an entry only changes when its low half is written first and its high half second. The table may be changed only while the receiver enable input is low. The check mode may be changed at any time. While the receiver is disabled, every frame is rejected. CRC, length checks and buffering are handled elsewhere.

Top module: `dmac_filter`

## Requirements
- R1: After reset `verdict_valid_o` is low, every table entry is invalid and the check mode is 0, so a frame arriving while enabled passes.
- R2: The destination address is the first six octets of the frame. Byte lane 0 of the start-of-frame beat is the first octet, which is bits 47:40 of the address. The address may span several beats. Octets after the sixth have no effect on the verdict.
- R3: For each frame, `verdict_valid_o` is high for exactly one cycle: the cycle after the clock edge that accepts the end-of-frame beat. It stays low at all other times.
- R4: In mode 0 (promiscuous), every frame passes.
- R5: In mode 1, a frame passes only if its destination equals the address of a valid table entry. With an empty table, every frame is rejected, including broadcast frames.
- R6: Mode 2 passes everything mode 1 passes, and also the broadcast destination (all 48 bits set).
- R7: Mode 3 passes everything mode 2 passes, and also any multicast destination (bit 0 of the first octet set, which is address bit 40).
- R8: The table occupies word addresses 32+2i (bits 31:0 = address bits 31:0) and 33+2i (bits 15:0 = address bits 47:32, bit 16 = valid) for entry i. The mode register is at word address 0, bits 1:0. A low write followed by a high write to the same entry loads that entry.
- R9: A high-half write that does not follow a low-half write to the same entry is ignored. The pending low half stays held, and a later high write to the matching entry commits it.
- R10: An entry whose valid bit is 0 never produces a match.
- R11: Table writes while `enable_i` is high are ignored. Mode writes take effect regardless of `enable_i`.
- R12: A frame whose end-of-frame beat is accepted while `enable_i` is low fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Receiver enable; low allows table writes and rejects frames |
| rx_valid_i | input | 1 | Beat valid |
| rx_sof_i | input | 1 | Beat is the first of a frame |
| rx_eof_i | input | 1 | Beat is the last of a frame |
| rx_data_i | input | DATA_W | Beat data, byte lane 0 first on the wire |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| verdict_valid_o | output | 1 | Verdict strobe, one per frame |
| verdict_pass_o | output | 1 | Frame may pass (qualified by verdict_valid_o) |

## Verification
The check is tried with unicast addresses that are present, absent, or present but marked invalid. It is also tried with the all-ones broadcast address and with a multicast address, under each of the four modes. This separates the table match from the broadcast term and from the multicast term. Some frames run longer than two beats and carry filler bytes after the address, which shows that only the first six octets decide the verdict. The write sequences test the write-order rule with three cases: a high half with nothing pending, a high half aimed at the wrong entry, and a later high half that completes the pending entry. A write attempted while enabled must leave the table unchanged, and a frame sent while disabled must be rejected.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int MAC_W      = 48;
  localparam int DA_OCTETS  = 6;
  localparam int REG_DW     = 32;

  typedef enum logic [1:0] {
    MODE_ANY       = 2'd0,
    MODE_TABLE     = 2'd1,
    MODE_TBL_BC    = 2'd2,
    MODE_TBL_BC_MC = 2'd3
  } chk_mode_e;
endpackage

// File: rtl/dmac_addr_grab.sv
module dmac_addr_grab
  import dmac_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sof_i,
  input  logic [8*BYTES-1:0] data_i,
  output logic [MAC_W-1:0]   da_o
);
  logic [3:0]       cnt_q, cnt_n, base;
  logic [MAC_W-1:0] da_q, da_n;

  // address including the current beat, so a verdict at eof sees every octet
  always_comb begin
    base = sof_i ? 4'd0 : cnt_q;
    da_n = sof_i ? '0 : da_q;
    for (int b = 0; b < BYTES; b++) begin
      if (int'(base) + b < DA_OCTETS)
        da_n[(MAC_W-1-8*(int'(base)+b)) -: 8] = data_i[8*b +: 8];
    end
    if (int'(base) + BYTES >= DA_OCTETS) cnt_n = 4'(DA_OCTETS);
    else                                 cnt_n = 4'(int'(base) + BYTES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      da_q  <= '0;
    end else if (valid_i) begin
      cnt_q <= cnt_n;
      da_q  <= da_n;
    end
  end

  assign da_o = da_n;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DA_OCTETS);
endmodule

// File: rtl/dmac_table.sv
module dmac_table
  import dmac_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AW      = $clog2(ENTRIES) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_allow_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [MAC_W-1:0]  da_i,
  output logic              hit_o
);
  localparam int IDX_W = AW - 2;
  localparam int HI_W  = MAC_W - REG_DW;

  logic [ENTRIES-1:0][MAC_W-1:0] mac_q;
  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0]            hit_vec;
  logic [REG_DW-1:0]             lo_hold_q;
  logic [IDX_W-1:0]              lo_idx_q;
  logic                          lo_pend_q;

  logic             tbl_wr, lo_wr, hi_wr, commit;
  logic [IDX_W-1:0] idx;

  assign idx    = addr_i[AW-2:1];
  assign tbl_wr = we_i && wr_allow_i && addr_i[AW-1] && (int'(idx) < ENTRIES);
  assign lo_wr  = tbl_wr && !addr_i[0];
  assign hi_wr  = tbl_wr &&  addr_i[0];
  assign commit = hi_wr && lo_pend_q && (lo_idx_q == idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_hold_q <= '0;
      lo_idx_q  <= '0;
      lo_pend_q <= 1'b0;
    end else if (lo_wr) begin
      lo_hold_q <= wdata_i;
      lo_idx_q  <= idx;
      lo_pend_q <= 1'b1;
    end else if (commit) begin
      lo_pend_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mac_q[i] <= '0;
        vld_q[i] <= 1'b0;
      end else if (commit && (int'(idx) == i)) begin
        mac_q[i] <= {wdata_i[HI_W-1:0], lo_hold_q};
        vld_q[i] <= wdata_i[HI_W];
      end
    end
    assign hit_vec[i] = vld_q[i] && (mac_q[i] == da_i);
  end

  assign hit_o = |hit_vec;

  // R11
  locked_tbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_allow_i |=> ($stable(vld_q) && $stable(mac_q)));
  // R9
  ordered_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(vld_q) || !$stable(mac_q)) |-> $past(lo_pend_q));
  // R10
  valid_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q == '0) |-> !hit_o);
endmodule

// File: rtl/dmac_verdict.sv
module dmac_verdict
  import dmac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eof_fire_i,
  input  logic             enable_i,
  input  chk_mode_e        mode_i,
  input  logic [MAC_W-1:0] da_i,
  input  logic             hit_i,
  output logic             verdict_valid_o,
  output logic             verdict_pass_o
);
  logic is_bc, is_mc, pass_n;

  assign is_bc = &da_i;
  assign is_mc = da_i[MAC_W-8];

  always_comb begin
    unique case (mode_i)
      MODE_ANY:       pass_n = 1'b1;
      MODE_TABLE:     pass_n = hit_i;
      MODE_TBL_BC:    pass_n = hit_i || is_bc;
      MODE_TBL_BC_MC: pass_n = hit_i || is_bc || is_mc;
      default:        pass_n = 1'b0;
    endcase
    pass_n = pass_n && enable_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_valid_o <= 1'b0;
      verdict_pass_o  <= 1'b0;
    end else begin
      verdict_valid_o <= eof_fire_i;
      verdict_pass_o  <= eof_fire_i && pass_n;
    end
  end

  // R3
  one_per_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> $past(eof_fire_i));
  // R12
  disabled_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_pass_o |-> $past(enable_i));
  // R4
  promisc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_fire_i && enable_i && mode_i == MODE_ANY) |=> verdict_pass_o);
  // R5
  table_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_fire_i && mode_i == MODE_TABLE && !hit_i) |=> !verdict_pass_o);
endmodule

// File: rtl/dmac_filter.sv
module dmac_filter
  import dmac_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int ENTRIES = 16,
  localparam int AW      = $clog2(ENTRIES) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic              verdict_valid_o,
  output logic              verdict_pass_o
);
  localparam int BYTES = DATA_W / 8;

  chk_mode_e        mode_q;
  logic [MAC_W-1:0] da;
  logic             hit, eof_fire;

  assign eof_fire = rx_valid_i && rx_eof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mode_q <= MODE_ANY;
    else if (reg_we_i && reg_addr_i == '0)   mode_q <= chk_mode_e'(reg_wdata_i[1:0]);
  end

  dmac_addr_grab #(.BYTES(BYTES)) u_grab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .sof_i   (rx_sof_i),
    .data_i  (rx_data_i),
    .da_o    (da)
  );

  dmac_table #(.ENTRIES(ENTRIES), .AW(AW)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_allow_i (!enable_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .da_i       (da),
    .hit_o      (hit)
  );

  dmac_verdict u_verdict (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .eof_fire_i      (eof_fire),
    .enable_i        (enable_i),
    .mode_i          (mode_q),
    .da_i            (da),
    .hit_i           (hit),
    .verdict_valid_o (verdict_valid_o),
    .verdict_pass_o  (verdict_pass_o)
  );
endmodule

// File: tb/dmac_filter_test.sv
`timescale 1ns/1ps
module dmac_filter_test;
  localparam int DATA_W = 32;
  localparam int AW     = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0;
  logic rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [DATA_W-1:0] rx_data_i = '0;
  logic reg_we_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic verdict_valid_o, verdict_pass_o;

  int n_chk = 0, n_bad = 0, n_frames = 0, n_verdicts = 0;

  localparam logic [47:0] MAC_A  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_B  = 48'h0A_BB_CC_DD_EE_01;
  localparam logic [47:0] MAC_C  = 48'h06_77_88_99_AA_BB;
  localparam logic [47:0] MAC_U  = 48'h04_00_00_00_00_99;
  localparam logic [47:0] MAC_BC = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MAC_MC = 48'h01_00_5E_00_00_01;

  always #2 clk = ~clk;

  dmac_filter #(.DATA_W(DATA_W), .ENTRIES(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i),
    .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i), .rx_eof_i(rx_eof_i),
    .rx_data_i(rx_data_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .verdict_valid_o(verdict_valid_o),
    .verdict_pass_o(verdict_pass_o)
  );

  always @(posedge clk) if (rst_ni && verdict_valid_o) n_verdicts++;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = AW'(addr); reg_wdata_i = data;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic wr_lo(input int i, input logic [47:0] mac);
    wr(32 + 2*i, mac[31:0]);
  endtask

  task automatic wr_hi(input int i, input logic [47:0] mac, input logic vld);
    wr(33 + 2*i, {15'b0, vld, mac[47:32]});
  endtask

  task automatic send(input logic [47:0] da, input int beats, input logic exp, input string tag);
    for (int k = 0; k < beats; k++) begin
      @(negedge clk);
      rx_valid_i = 1'b1;
      rx_sof_i   = (k == 0);
      rx_eof_i   = (k == beats - 1);
      if (k == 0)      rx_data_i = {da[23:16], da[31:24], da[39:32], da[47:40]};
      else if (k == 1) rx_data_i = {8'hEE, 8'hEE, da[7:0], da[15:8]};
      else             rx_data_i = 32'hFF_FF_FF_FF ^ (32'h1 << k);
      @(posedge clk); #1;
      if (k < beats - 1) check(32'(verdict_valid_o), 0, {tag, " R3 no verdict mid-frame"});
    end
    n_frames++;
    check(32'(verdict_valid_o), 1, {tag, " R3 verdict strobe"});
    check(32'(verdict_pass_o), 32'(exp), tag);
    @(negedge clk);
    rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
    @(posedge clk); #1;
    check(32'(verdict_valid_o), 0, {tag, " R3 single pulse"});
  endtask

  task automatic t_reset;
    check(32'(verdict_valid_o), 0, "R1 verdict idle after reset");
    enable_i = 1'b1;
    send(MAC_U, 2, 1'b1, "R1 reset mode passes");
  endtask

  task automatic t_mode0;
    send(MAC_BC, 2, 1'b1, "R4 broadcast in mode 0");
    send(MAC_MC, 3, 1'b1, "R4 multicast in mode 0");
  endtask

  task automatic t_mode1_empty;
    wr(0, 32'd1);
    send(MAC_U, 2, 1'b0, "R5 empty table rejects unicast");
    send(MAC_BC, 2, 1'b0, "R5 mode 1 rejects broadcast");
  endtask

  task automatic t_load;
    enable_i = 1'b0;
    wr_lo(3, MAC_A); wr_hi(3, MAC_A, 1'b1);
    enable_i = 1'b1;
    send(MAC_A, 2, 1'b1, "R8 loaded entry matches");
    send(MAC_B, 2, 1'b0, "R5 absent address rejected");
    send(MAC_A, 5, 1'b1, "R2 long frame, trailing octets ignored");
  endtask

  task automatic t_order;
    enable_i = 1'b0;
    wr_hi(5, MAC_B, 1'b1);
    enable_i = 1'b1;
    send(MAC_B, 2, 1'b0, "R9 high half alone ignored");
    enable_i = 1'b0;
    wr_lo(5, MAC_B); wr_hi(4, MAC_B, 1'b1);
    enable_i = 1'b1;
    send(MAC_B, 2, 1'b0, "R9 high half to wrong entry ignored");
    enable_i = 1'b0;
    wr_hi(5, MAC_B, 1'b1);
    enable_i = 1'b1;
    send(MAC_B, 2, 1'b1, "R9 pending low committed");
  endtask

  task automatic t_invalid;
    enable_i = 1'b0;
    wr_lo(5, MAC_B); wr_hi(5, MAC_B, 1'b0);
    enable_i = 1'b1;
    send(MAC_B, 2, 1'b0, "R10 invalid entry does not match");
  endtask

  task automatic t_locked;
    wr_lo(6, MAC_C); wr_hi(6, MAC_C, 1'b1);
    send(MAC_C, 2, 1'b0, "R11 write while enabled ignored");
    wr(0, 32'd2);
    send(MAC_BC, 2, 1'b1, "R6 R11 mode 2 broadcast passes");
    send(MAC_MC, 2, 1'b0, "R6 mode 2 rejects multicast");
    send(MAC_A, 2, 1'b1, "R6 mode 2 table hit passes");
  endtask

  task automatic t_mode3;
    wr(0, 32'd3);
    send(MAC_MC, 2, 1'b1, "R7 mode 3 multicast passes");
    send(MAC_U, 2, 1'b0, "R7 mode 3 unknown unicast rejected");
    send(MAC_BC, 3, 1'b1, "R7 mode 3 broadcast passes");
  endtask

  task automatic t_disabled;
    enable_i = 1'b0;
    send(MAC_A, 2, 1'b0, "R12 disabled rejects frame");
    repeat (2) @(posedge clk);
    #1;
    check(32'(n_verdicts), 32'(n_frames), "R3 one verdict per frame");
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_mode0();
    t_mode1_empty();
    t_load();
    t_order();
    t_invalid();
    t_locked();
    t_mode3();
    t_disabled();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule